// File: doc/BRIEF.md
# Fractional Audio Clock Divider

This block derives an audio bit or frame clock from a fast source. Each output period lasts an integer number of source ticks N. Some periods last N+1 ticks. Which periods are lengthened is set by a 16-bit stretch pattern that is replayed one bit per period. The highest set bit of the pattern fixes how many periods make up one repeat. The number of set bits fixes how many of those periods are lengthened. The bit order fixes where in the repeat they fall. The average ratio is therefore N plus a fraction whose denominator and numerator both come straight from the pattern.

Ticks come from one of two candidates. With the select set, every cycle of the block's own clock is a tick. With the select clear, only cycles on which an already divided tick input is high are counted. Settings are written through a small address/data write port. Divider changes wait for the end of the running period. Pattern changes wait for the end of the running repeat, so a running sequence is never torn.

Top module: `frac_clkdiv`

## Requirements
- R1: After reset `clk_out` is low and stays low until the enable is set by a write.
- R2: While the enable is clear, `clk_out` is low from the cycle after the enable register clears. Re-enabling restarts the pattern at its top set bit.
- R3: With a pattern of zero, every output period lasts exactly N ticks, where N is the divide field.
- R4: A divide field of 0 or 1 is treated as 2.
- R5: Each period starts with `clk_out` rising. It stays high for floor(P/2) ticks and is low for the remaining ticks of the period of length P.
- R6: For a nonzero pattern with top set bit at position m, one repeat is m+1 periods. Period k of a repeat uses pattern bit m-k, so the repeat starts at the top bit and walks down to bit 0. A bit of 1 lengthens that period to N+1. For example, 0x0110 gives lengthened periods in the order 1,0,0,0,1,0,0,0,0, and 0xFEEE gives 1111 1110 1110 1110.
- R7: A new divide value written during a period takes effect at the next period boundary. The running period completes at its old length.
- R8: A new pattern written during a repeat takes effect at the start of the next repeat.
- R9: With the select bit set, every clock cycle is a tick. With the select bit clear, only cycles with `alt_tick` high are ticks, and `clk_out` does not change on any other cycle.
- R10: A write to address 0 loads the divide field from data bits [11:0], the enable from bit 12 and the select from bit 13. Divider and enable may be set in the same write. A write to address 1 loads the pattern from bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock; also the undivided tick source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| alt_tick | input | 1 | Single-cycle pulses from an already divided source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Configuration address (0 control, 1 pattern) |
| cfg_wdata | input | 16 | Configuration write data |
| clk_out | output | 1 | Divided clock |

## Verification
The main function is tried with four kinds of pattern. A zero pattern at several divide values separates the integer path and the high-phase rounding from the stretch logic. A single-bit pattern stretches every period. The sparse 0x0110 pattern over two full repeats shows that the denominator comes from the top bit and that the stretched periods fall at the right positions. The dense 0xFEEE pattern shows the walk order across nibble boundaries. Mid-period and mid-repeat writes, a disable and re-enable, and the divided tick source separate the boundary rules from the counting itself.

// File: rtl/frac_clkdiv_pkg.sv
package frac_clkdiv_pkg;
  localparam int DIV_W_DEF  = 12;
  localparam int FRAC_W_DEF = 16;

  typedef enum logic {
    CFG_CTRL = 1'b0,
    CFG_PAT  = 1'b1
  } cfg_addr_e;

  localparam int CTRL_EN_BIT  = 12;
  localparam int CTRL_SEL_BIT = 13;
endpackage

// File: rtl/fcd_cfg_regs.sv
module fcd_cfg_regs
  import frac_clkdiv_pkg::*;
#(
  parameter int DIV_W  = DIV_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              addr,
  input  logic [FRAC_W-1:0] wdata,
  output logic [DIV_W-1:0]  div_o,
  output logic              en_o,
  output logic              sel_o,
  output logic [FRAC_W-1:0] pat_o
);
  logic [DIV_W-1:0]  div_q, div_d;
  logic              en_q, en_d;
  logic              sel_q, sel_d;
  logic [FRAC_W-1:0] pat_q, pat_d;

  always_comb begin
    div_d = div_q;
    en_d  = en_q;
    sel_d = sel_q;
    pat_d = pat_q;
    if (we) begin
      if (cfg_addr_e'(addr) == CFG_CTRL) begin
        div_d = wdata[DIV_W-1:0];
        en_d  = wdata[CTRL_EN_BIT];
        sel_d = wdata[CTRL_SEL_BIT];
      end else begin
        pat_d = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      pat_q <= '0;
    end else begin
      div_q <= div_d;
      en_q  <= en_d;
      sel_q <= sel_d;
      pat_q <= pat_d;
    end
  end

  assign div_o = div_q;
  assign en_o  = en_q;
  assign sel_o = sel_q;
  assign pat_o = pat_q;

  // R10: a control write reaches the enable on the next cycle
  a_r10_en_load: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (addr == 1'b0)) |=> (en_q == $past(wdata[CTRL_EN_BIT])));
endmodule

// File: rtl/fcd_pattern_seq.sv
module fcd_pattern_seq #(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv,
  input  logic              first,
  input  logic [FRAC_W-1:0] pat_live,
  output logic              stretch
);
  localparam int IDX_W = (FRAC_W > 1) ? $clog2(FRAC_W) : 1;

  function automatic logic [IDX_W-1:0] top_bit(input logic [FRAC_W-1:0] p);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int b = 0; b < FRAC_W; b++) begin
      if (p[b]) r = IDX_W'(b);
    end
    return r;
  endfunction

  logic [FRAC_W-1:0] pat_q, pat_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              wrap_q, wrap_d;
  logic              new_rep;
  logic [IDX_W-1:0]  msb_live;

  assign new_rep  = first || wrap_q;
  assign msb_live = top_bit(pat_live);
  assign stretch  = new_rep ? (|pat_live) : pat_q[idx_q];

  always_comb begin
    pat_d  = pat_q;
    idx_d  = idx_q;
    wrap_d = wrap_q;
    if (!en) begin
      wrap_d = 1'b1;
    end else if (adv) begin
      if (new_rep) begin
        pat_d  = pat_live;
        idx_d  = msb_live - IDX_W'(1);
        wrap_d = (msb_live == '0);
      end else begin
        idx_d  = idx_q - IDX_W'(1);
        wrap_d = (idx_q == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q  <= '0;
      idx_q  <= '0;
      wrap_q <= 1'b1;
    end else begin
      pat_q  <= pat_d;
      idx_q  <= idx_d;
      wrap_q <= wrap_d;
    end
  end

  // R6: inside a repeat the walk index stays below the repeat's top bit
  a_r6_idx_below_top: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_q |-> (idx_q < top_bit(pat_q)));
  // R8: the pattern in use only changes where a repeat begins
  a_r8_pat_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_q |=> $stable(pat_q));
endmodule

// File: rtl/fcd_period_gen.sv
module fcd_period_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  input  logic             stretch,
  output logic             begin_o,
  output logic             first_o,
  output logic             clk_o
);
  localparam int PW = DIV_W + 1;
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [PW-1:0]    cnt_q, cnt_d;
  logic [PW-1:0]    per_q, per_d;
  logic [PW-1:0]    hi_q, hi_d;
  logic             run_q, run_d;
  logic             out_q, out_d;
  logic             last;
  logic             begin_per;
  logic [DIV_W-1:0] eff_div;

  assign last      = (cnt_q == per_q - PW'(1));
  assign begin_per = en && tick && (!run_q || last);
  assign eff_div   = (div < MIN_DIV) ? MIN_DIV : div;

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    hi_d  = hi_q;
    run_d = run_q;
    out_d = out_q;
    if (!en) begin
      cnt_d = '0;
      run_d = 1'b0;
      out_d = 1'b0;
    end else if (begin_per) begin
      per_d = {1'b0, eff_div} + {{DIV_W{1'b0}}, stretch};
      hi_d  = per_d >> 1;
      cnt_d = '0;
      run_d = 1'b1;
      out_d = 1'b1;
    end else if (tick) begin
      cnt_d = cnt_q + PW'(1);
      out_d = (cnt_q + PW'(1)) < hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      hi_q  <= '0;
      run_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      hi_q  <= hi_d;
      run_q <= run_d;
      out_q <= out_d;
    end
  end

  assign begin_o = begin_per;
  assign first_o = !run_q;
  assign clk_o   = out_q;

  // R5: the output rises only as a period begins
  a_r5_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> (run_q && cnt_q == '0));
  // R4: a running period is never shorter than two ticks
  a_r4_min_period: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (per_q >= PW'(2)));
  // R7: the period length is held until the period ends
  a_r7_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_q && !(tick && last)) |=> $stable(per_q));
endmodule

// File: rtl/frac_clkdiv.sv
module frac_clkdiv
  import frac_clkdiv_pkg::*;
#(
  parameter int DIV_W  = DIV_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_tick,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [FRAC_W-1:0] cfg_wdata,
  output logic              clk_out
);
  logic [DIV_W-1:0]  div;
  logic              en;
  logic              sel;
  logic [FRAC_W-1:0] pat;
  logic              tick;
  logic              stretch;
  logic              begin_per;
  logic              first;

  fcd_cfg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .div_o (div),
    .en_o  (en),
    .sel_o (sel),
    .pat_o (pat)
  );

  assign tick = sel ? 1'b1 : alt_tick;

  fcd_pattern_seq #(.FRAC_W(FRAC_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .adv      (begin_per),
    .first    (first),
    .pat_live (pat),
    .stretch  (stretch)
  );

  fcd_period_gen #(.DIV_W(DIV_W)) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .tick    (tick),
    .div     (div),
    .stretch (stretch),
    .begin_o (begin_per),
    .first_o (first),
    .clk_o   (clk_out)
  );

  // R2: a cleared enable forces the output low one cycle later
  a_r2_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !clk_out);
  // R9: without a tick the output keeps its level
  a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(clk_out));
endmodule

// File: tb/frac_clkdiv_bench.sv
module frac_clkdiv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_MAX   = 2000;

  logic        clk;
  logic        rst_n;
  logic        alt_tick;
  logic        alt_run;
  logic        cfg_we;
  logic        cfg_addr;
  logic [15:0] cfg_wdata;
  logic        clk_out;

  int n_checks;
  int n_fail;
  int per_a [64];
  int hi_a  [64];

  frac_clkdiv u_frac_clkdiv (
    .clk       (clk),
    .rst_n     (rst_n),
    .alt_tick  (alt_tick),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .clk_out   (clk_out)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // divided tick source: one pulse every third cycle while alt_run is set
  initial begin
    int ph;
    ph = 0;
    alt_tick = 1'b0;
    forever begin
      @(negedge clk);
      if (alt_run) begin
        ph = (ph + 1) % 3;
        alt_tick = (ph == 0);
      end else begin
        ph = 0;
        alt_tick = 1'b0;
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] ctrl(input int n, input bit en, input bit sel);
    logic [15:0] w;
    w = '0;
    w[11:0] = n[11:0];
    w[12] = en;
    w[13] = sel;
    return w;
  endfunction

  function automatic int exp_per(input int n, input int pat, input int k);
    int m;
    int ne;
    m = -1;
    ne = (n < 2) ? 2 : n;
    for (int b = 0; b < 16; b++) if (pat[b]) m = b;
    if (m < 0) return ne;
    return ne + ((pat >> (m - (k % (m + 1)))) & 1);
  endfunction

  // measure k periods in clock cycles, starting at the next rising edge
  task automatic measure(input int k);
    bit prev;
    bit got;
    int w;
    prev = 1'b0;
    got = 1'b0;
    w = 0;
    while (!got && w < WAIT_MAX) begin
      @(negedge clk);
      if (clk_out && !prev) got = 1'b1;
      prev = clk_out;
      w++;
    end
    for (int i = 0; i < k; i++) begin
      per_a[i] = 0;
      hi_a[i] = 0;
    end
    if (!got) return;
    for (int i = 0; i < k; i++) begin
      int p;
      int h;
      bit done;
      p = 1;
      h = 1;
      done = 1'b0;
      while (!done && p < WAIT_MAX) begin
        @(negedge clk);
        if (clk_out && !prev) done = 1'b1;
        else begin
          p++;
          if (clk_out) h++;
        end
        prev = clk_out;
      end
      per_a[i] = p;
      hi_a[i] = h;
    end
  endtask

  task automatic stop_all();
    wr(1'b0, ctrl(0, 1'b0, 1'b1));
    wr(1'b1, 16'h0000);
    repeat (3) @(negedge clk);
  endtask

  // run a pattern case on the fast source: period and high phase of each
  task automatic run_case(input string req, input int n, input int pat, input int k);
    wr(1'b1, pat[15:0]);
    wr(1'b0, ctrl(n, 1'b1, 1'b1));
    measure(k);
    for (int i = 0; i < k; i++) begin
      int e;
      e = exp_per(n, pat, i);
      chk(per_a[i] == e, req, per_a[i], e);
      chk(hi_a[i] == e / 2, "R5", hi_a[i], e / 2);
    end
    stop_all();
  endtask

  task automatic t_reset();
    int highs;
    highs = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (clk_out) highs++;
    end
    chk(highs == 0, "R1", highs, 0);
  endtask

  task automatic t_integer();
    run_case("R3", 5, 0, 6);
    run_case("R3", 4, 0, 4);
    run_case("R3", 7, 0, 4);
    run_case("R3", 100, 0, 2);
  endtask

  task automatic t_min_div();
    run_case("R4", 1, 0, 3);
    run_case("R4", 0, 0, 3);
  endtask

  task automatic t_patterns();
    run_case("R6", 10, 16'h0110, 18);
    run_case("R6", 3, 16'hFEEE, 16);
    run_case("R6", 6, 16'h0001, 4);
  endtask

  task automatic t_div_change();
    wr(1'b1, 16'h0000);
    wr(1'b0, ctrl(8, 1'b1, 1'b1));
    fork
      measure(3);
      begin
        repeat (4) @(negedge clk);
        wr(1'b0, ctrl(4, 1'b1, 1'b1));
      end
    join
    chk(per_a[0] == 8, "R7", per_a[0], 8);
    chk(per_a[1] == 4, "R7", per_a[1], 4);
    chk(per_a[2] == 4, "R7", per_a[2], 4);
    stop_all();
  endtask

  task automatic t_pat_change();
    wr(1'b1, 16'h0110);
    wr(1'b0, ctrl(4, 1'b1, 1'b1));
    fork
      measure(12);
      begin
        repeat (7) @(negedge clk);
        wr(1'b1, 16'h0000);
      end
    join
    for (int i = 0; i < 12; i++) begin
      int e;
      e = (i < 9) ? exp_per(4, 16'h0110, i) : 4;
      chk(per_a[i] == e, "R8", per_a[i], e);
    end
    stop_all();
  endtask

  task automatic t_disable();
    int highs;
    wr(1'b1, 16'h0002);
    wr(1'b0, ctrl(6, 1'b1, 1'b1));
    measure(3);
    chk(per_a[0] == 7 && per_a[1] == 6 && per_a[2] == 7, "R2", per_a[1], 6);
    wr(1'b0, ctrl(6, 1'b0, 1'b1));
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (clk_out) highs++;
    end
    chk(highs == 0, "R2", highs, 0);
    wr(1'b0, ctrl(6, 1'b1, 1'b1));
    measure(2);
    chk(per_a[0] == 7, "R2", per_a[0], 7);
    chk(per_a[1] == 6, "R2", per_a[1], 6);
    stop_all();
  endtask

  task automatic t_alt_source();
    alt_run = 1'b1;
    wr(1'b1, 16'h0000);
    wr(1'b0, ctrl(2, 1'b1, 1'b0));
    measure(3);
    for (int i = 0; i < 3; i++) begin
      chk(per_a[i] == 6, "R9", per_a[i], 6);
      chk(hi_a[i] == 3, "R9", hi_a[i], 3);
    end
    stop_all();
    wr(1'b1, 16'h0001);
    wr(1'b0, ctrl(3, 1'b1, 1'b0));
    measure(2);
    chk(per_a[0] == 12, "R9", per_a[0], 12);
    chk(hi_a[1] == 6, "R9", hi_a[1], 6);
    stop_all();
    alt_run = 1'b0;
  endtask

  task automatic t_same_write();
    // R10: divider and enable set together, pattern at address 1 first
    wr(1'b1, 16'h0001);
    wr(1'b0, ctrl(9, 1'b1, 1'b1));
    measure(2);
    chk(per_a[0] == 10, "R10", per_a[0], 10);
    chk(per_a[1] == 10, "R10", per_a[1], 10);
    stop_all();
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    alt_run = 1'b0;
    cfg_we = 1'b0;
    cfg_addr = 1'b0;
    cfg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_integer();
    t_min_div();
    t_patterns();
    t_div_change();
    t_pat_change();
    t_disable();
    t_alt_source();
    t_same_write();
    report();
  end
endmodule